// File: doc/BRIEF.md
# Quad Reloading Timer with Cascade

This block holds four independent 16-bit up-counters behind a small byte-wide register port. Each timer occupies a 4-byte slot: two bytes carry the 16-bit value, one byte holds its control bits, and one byte is reserved. Software writes a reload value into the value bytes, but reading those same bytes returns the live count, so the reload can never be read back. Writing the control byte with the run bit going from clear to set arms a one-shot load that copies the reload value into the counter on the following clock.

A running timer advances on ticks from a shared prescaler that divides the system clock by 1, 64, 256 or 1024. When the count passes 0xFFFF it is refilled from the reload value, a one-cycle overflow pulse leaves the block and, if enabled, a one-cycle interrupt request pulse goes with it. Timers 1 to 3 can instead be chained: in cascade mode each one advances once per overflow pulse of its lower neighbour, which builds 32-, 48- or 64-bit counts. The register port is a plain synchronous write strobe with a combinational read path; the block has no streaming data interface, so no valid/ready handshake applies and the port never stalls.

Top module: `tmr_quad`

## Requirements
- R1: After reset every count, reload value and control field is zero, and no overflow or interrupt pulse is produced.
- R2: Timer n sits at byte address 4n; a write to byte 0 (low) or byte 1 (high) changes only the reload value, and a read of byte 0 or 1 returns the low or high byte of the live count.
- R3: Control byte 2 holds the prescaler code in bits 1:0, cascade in bit 2, interrupt enable in bit 6 and run in bit 7; it reads back those fields with bits 5:3 as zero.
- R4: Byte 3 of every slot reads as zero and writes to it change nothing.
- R5: A control write that takes the run bit from 0 to 1 loads the counter with the reload value on the next clock.
- R6: A running counter at 0xFFFF that receives a tick reloads and emits a one-cycle overflow pulse, so with divide-by-1 the pulses repeat every 65536 minus reload cycles.
- R7: An interrupt pulse accompanies each overflow pulse when the interrupt enable bit is set, and never appears otherwise.
- R8: Prescaler codes 0, 1, 2, 3 tick the counter every 1, 64, 256 and 1024 clocks.
- R9: A timer with the run bit clear keeps its count and produces no overflow.
- R10: With cascade set, timers 1 to 3 advance once per overflow pulse of the next lower timer (one clock after it) and ignore their prescaler code.
- R11: The cascade bit has no effect on timer 0, which keeps using its prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 8 | Combinational read data |
| ovf | output | 4 | Per-timer one-cycle overflow pulse |
| irq | output | 4 | Per-timer one-cycle interrupt request pulse |

## Verification
A wrong count or a stuck prescaler phase shows at the ports as an overflow interval that differs from (65536 minus reload) times the division, visible within one period of the timer. A lost or spurious arm flag shows on the very next read of the value bytes, which then differ from the reload value just after the enabling write. A mis-routed cascade source shows as a chained timer whose overflow interval follows its own prescaler instead of its neighbour, within a few neighbour periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_PRESC = 4;
  localparam int PRESC_LOG [NUM_PRESC] = '{0, 6, 8, 10};
  localparam int PRESC_W = PRESC_LOG[NUM_PRESC-1];

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic       casc;
    logic [1:0] sel;
  } tmr_ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(tmr_ctrl_t c);
    return {c.run, c.irq_en, 3'b000, c.casc, c.sel};
  endfunction

  function automatic tmr_ctrl_t byte_to_ctrl(logic [7:0] b);
    tmr_ctrl_t c;
    c.run    = b[7];
    c.irq_en = b[6];
    c.casc   = b[2];
    c.sel    = b[1:0];
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_PRESC-1:0] tick
);
  logic [PRESC_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_PRESC; k++) begin : g_tap
    localparam logic [PRESC_W-1:0] MASK = PRESC_W'((1 << PRESC_LOG[k]) - 1);
    assign tick[k] = ((div_q & MASK) == MASK);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW      = 16,
  parameter bit CASC_OK = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic                 wr_ctl,
  input  logic [7:0]           wr_data,
  input  logic [NUM_PRESC-1:0] presc_tick,
  input  logic                 casc_in,
  output logic [CW-1:0]        cnt,
  output logic [CW-1:0]        reload,
  output tmr_ctrl_t            ctrl,
  output logic                 arm,
  output logic                 ovf,
  output logic                 irq
);
  localparam logic [CW-1:0] TOP = '1;

  logic tick, wrap;

  assign tick = (CASC_OK && ctrl.casc) ? casc_in : presc_tick[ctrl.sel];
  assign wrap = !arm && ctrl.run && tick && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload <= '0;
      ctrl   <= '0;
      arm    <= 1'b0;
      cnt    <= '0;
      ovf    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_lo) reload[7:0]    <= wr_data;
      if (wr_hi) reload[CW-1:8] <= wr_data[CW-9:0];

      if (wr_ctl && !ctrl.run && wr_data[7]) arm <= 1'b1;
      else                                   arm <= 1'b0;
      if (wr_ctl) ctrl <= byte_to_ctrl(wr_data);

      if (arm)                    cnt <= reload;
      else if (ctrl.run && tick)  cnt <= (cnt == TOP) ? reload : cnt + 1'b1;

      ovf <= wrap;
      irq <= wrap && ctrl.irq_en;
    end
  end
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_pkg::*;
#(
  parameter  int NUM = 4,
  localparam int CW  = 16,
  localparam int AW  = $clog2(NUM) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [NUM-1:0] ovf,
  output logic [NUM-1:0] irq
);
  localparam int SW = AW - 2;

  logic [NUM_PRESC-1:0] presc_tick;
  logic [NUM*CW-1:0]    cnt_all, reload_all;
  logic [NUM-1:0]       run_all, arm_all;
  logic [NUM-1:0][7:0]  ctl_byte;

  tmr_prescaler u_presc (.clk(clk), .rst_n(rst_n), .tick(presc_tick));

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    logic      hit, casc_src;
    tmr_ctrl_t ctl;

    assign hit = wr_en && (wr_addr[AW-1:2] == SW'(i));

    if (i == 0) begin : g_head
      assign casc_src = 1'b0;
    end else begin : g_chain
      assign casc_src = ovf[i-1];
    end

    tmr_channel #(.CW(CW), .CASC_OK(i != 0)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_lo (hit && wr_addr[1:0] == 2'd0),
      .wr_hi (hit && wr_addr[1:0] == 2'd1),
      .wr_ctl(hit && wr_addr[1:0] == 2'd2),
      .wr_data(wr_data), .presc_tick(presc_tick), .casc_in(casc_src),
      .cnt(cnt_all[i*CW +: CW]), .reload(reload_all[i*CW +: CW]),
      .ctrl(ctl), .arm(arm_all[i]), .ovf(ovf[i]), .irq(irq[i])
    );

    assign run_all[i]  = ctl.run;
    assign ctl_byte[i] = ctrl_to_byte(ctl);
  end

  always_comb begin
    logic [SW-1:0] s;
    s = rd_addr[AW-1:2];
    rd_data = 8'h00;
    if (int'(s) < NUM) begin
      case (rd_addr[1:0])
        2'd0:    rd_data = cnt_all[int'(s)*CW +: 8];
        2'd1:    rd_data = cnt_all[int'(s)*CW + 8 +: 8];
        2'd2:    rd_data = ctl_byte[s];
        default: rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/tmr_quad_chk.sv
module tmr_quad_chk #(
  parameter int NUM = 4,
  parameter int CW  = 16,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     rd_addr,
  input logic [7:0]        rd_data,
  input logic [NUM-1:0]    ovf,
  input logic [NUM-1:0]    irq,
  input logic [NUM-1:0]    run_all,
  input logic [NUM-1:0]    arm_all,
  input logic [NUM*CW-1:0] cnt_all,
  input logic [NUM*CW-1:0] reload_all
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[1:0] == 2'd3) |-> (rd_data == 8'h00)); // R4

  for (genvar i = 0; i < NUM; i++) begin : g_chk
    AST_IRQ_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> ovf[i]); // R7
    AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      arm_all[i] |=> (cnt_all[i*CW +: CW] == $past(reload_all[i*CW +: CW]))); // R5
    AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_all[i] && !arm_all[i]) |=> !ovf[i]); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_all[i] && !arm_all[i]) |=> $stable(cnt_all[i*CW +: CW])); // R9
  end
endmodule

bind tmr_quad tmr_quad_chk #(.NUM(NUM), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .ovf(ovf), .irq(irq), .run_all(run_all), .arm_all(arm_all),
  .cnt_all(cnt_all), .reload_all(reload_all)
);

// File: tb/tmr_quad_bench.sv
`timescale 1ns/1ps
module tmr_quad_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] ovf, irq;

  always #2.5 clk = ~clk;

  tmr_quad u_tmr_quad (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ovf(ovf), .irq(irq));

  typedef struct { string tag; int exp; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int last_t [4], last_iv [4], n_ovf [4], n_irq [4];
  event ev_rd;

  // scoreboard compare: pops the oldest expectation
  function automatic void observe(int act);
    item_t it;
    it = sb_q.pop_front();
    n_chk++;
    if (act != it.exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
    end
  endfunction

  // monitor: pulse timing and read results, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    for (int c = 0; c < 4; c++) begin
      if (ovf[c]) begin last_iv[c] = cyc - last_t[c]; last_t[c] = cyc; n_ovf[c]++; end
      if (irq[c]) n_irq[c]++;
    end
  end

  initial forever begin
    @(ev_rd);
    @(negedge clk);
    observe(int'(rd_data));
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(posedge clk); #1 rd_addr = a;
    sb_q.push_back('{tag, exp});
    -> ev_rd;
    @(posedge clk);
  endtask

  task automatic period(input int c, input int exp, input string tag);
    int target;
    target = n_ovf[c] + 3;
    wait (n_ovf[c] >= target);
    sb_q.push_back('{tag, exp});
    observe(last_iv[c]);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    n_chk++;
    if (ovf !== 4'h0 || irq !== 4'h0) begin
      n_fail++; $display("FAIL R1 pulses actual=%h/%h expected=0/0", ovf, irq);
    end
    for (int a = 0; a < 16; a++) rd(4'(a), 0, $sformatf("R1 reset byte %0d", a));

    // R2 reload write does not reach the count
    wr(4'd8, 8'h34); wr(4'd9, 8'h12);
    rd(4'd8, 8'h00, "R2 count lo after reload write");
    rd(4'd9, 8'h00, "R2 count hi after reload write");
    // R5 arm then disarm next cycle: count holds reload
    @(posedge clk); #1 wr_en = 1'b1; wr_addr = 4'd10; wr_data = 8'h80;
    @(posedge clk); #1 wr_data = 8'h00;
    @(posedge clk); #1 wr_en = 1'b0;
    rd(4'd8, 8'h34, "R5 loaded lo");
    rd(4'd9, 8'h12, "R5 loaded hi");
    repeat (40) @(posedge clk);
    rd(4'd8, 8'h34, "R9 idle holds lo");
    wr(4'd8, 8'hCD); wr(4'd9, 8'hAB);
    rd(4'd9, 8'h12, "R2 count unchanged by new reload");

    // R3 / R4 control layout
    wr(4'd14, 8'h7F);
    rd(4'd14, 8'h47, "R3 control readback");
    wr(4'd15, 8'hFF);
    rd(4'd15, 8'h00, "R4 reserved byte");
    rd(4'd14, 8'h47, "R4 reserved write left control alone");
    wr(4'd14, 8'h00);

    // R6 / R7 divide-by-1, irq enabled
    wr(4'd0, 8'hF0); wr(4'd1, 8'hFF);
    wr(4'd2, 8'hC0);
    period(0, 16, "R6 period div1 reload FFF0");
    n_irq[0] = 0; n_ovf[0] = 0;
    repeat (100) @(posedge clk);
    sb_q.push_back('{"R7 irq count equals ovf count", n_ovf[0]});
    observe(n_irq[0]);
    wr(4'd2, 8'h00); wr(4'd2, 8'h80);
    period(0, 16, "R6 period after re-arm");
    n_irq[0] = 0;
    repeat (100) @(posedge clk);
    sb_q.push_back('{"R7 no irq when disabled", 0});
    observe(n_irq[0]);

    // R8 prescalers
    wr(4'd2, 8'h00); wr(4'd0, 8'hFE); wr(4'd2, 8'h81);
    period(0, 128, "R8 div64 reload FFFE");
    wr(4'd2, 8'h00); wr(4'd0, 8'hFF); wr(4'd2, 8'h82);
    period(0, 256, "R8 div256 reload FFFF");
    wr(4'd2, 8'h00); wr(4'd2, 8'h83);
    period(0, 1024, "R8 div1024 reload FFFF");

    // R10 cascade on timer 1, own prescaler code 3 ignored
    wr(4'd2, 8'h00); wr(4'd0, 8'hF0); wr(4'd2, 8'h80);
    wr(4'd4, 8'hFC); wr(4'd5, 8'hFF); wr(4'd6, 8'h87);
    period(1, 64, "R10 cascade 4 x 16");
    // R11 cascade bit on timer 0 is ignored
    wr(4'd2, 8'h00); wr(4'd0, 8'hF8); wr(4'd2, 8'h84);
    period(0, 8, "R11 timer0 cascade ignored");
    period(1, 32, "R10 cascade follows new source period");

    summary();
  end
endmodule